// File: doc/BRIEF.md
# Time-Slot Octet Slip Buffer

This block sits between a low-rate receive path and a 2.048 Mbit/s PCM highway. Complete octets arrive in parallel with a one-cycle write enable, clocked by the recovered line clock. The block stores them and, once per frame, sends one octet as an eight-bit serial burst inside a chosen time slot on the local read clock. The slot position comes from one of two fixed time-slot strobes. A select pin chooses between them.

The two clocks are not locked to each other, so the number of new octets that arrive between two time-slot windows can be zero, one, or more than one. With one new octet, that octet is sent. With none, the octet sent last time is sent again and a repeat flag is raised for the burst. With more than one, only the newest is sent, the older ones are dropped, and a delete flag pulses. Every burst is always a whole octet, so octet alignment survives each slip.

Top module: `tslot_slip_buf`

## Requirements
- R1: After reset, `pcm_out` is 1 and both `rep_flag` and `del_flag` are 0.
- R2: The active strobe is `ts_a` while `ts_pick` is 1 and `ts_b` while `ts_pick` is 0. A pulse on the strobe that is not selected leaves `pcm_out` at 1 and both flags at 0.
- R3: The window opens at the first read-clock edge where the active strobe is sampled high after being low. At that edge and at the next seven edges, `pcm_out` takes the bits of the chosen octet in turn, most significant bit first.
- R4: `pcm_out` is 1 at every edge where the active strobe is sampled low, and also after the eighth bit while the strobe stays high.
- R5: If exactly one octet was written since the previous window opened, the window sends that octet and both flags stay 0.
- R6: If no octet was written since the previous window opened, the window sends the previously sent octet again, and `rep_flag` is 1 for exactly the eight burst bits.
- R7: If two or more octets were written since the previous window opened, the window sends only the last one written, and `del_flag` is 1 for the single cycle in which the first bit is on `pcm_out`.
- R8: `rep_flag` and `del_flag` are never high together, and `del_flag` is never high for two cycles in a row.
- R9: A window that opens before any octet has been written sends 8'hFF and raises `rep_flag`.
- R10: The write enable passes through a two-stage read-domain synchronizer. An octet written in the read-clock cycle just before a window opens is not seen by that window. It is sent by the following window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_en | input | 1 | Store `wr_octet` at this `wr_clk` edge |
| wr_octet | input | 8 | Assembled receive octet |
| rd_clk | input | 1 | Local 2.048 MHz read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| ts_a | input | 1 | First hard-wired time-slot strobe |
| ts_b | input | 1 | Second hard-wired time-slot strobe |
| ts_pick | input | 1 | 1 selects `ts_a`, 0 selects `ts_b` |
| pcm_out | output | 1 | Serial burst output, idles at 1 |
| rep_flag | output | 1 | High while a repeated octet is sent |
| del_flag | output | 1 | One-cycle pulse when an octet is dropped |

## Verification
Windows are opened after zero, one, two and three writes, so the tests can tell a normal send, a repeat, and a drop apart, and can confirm that the newest octet wins when the two slots wrap. A write placed one cycle before a window opens tests the synchronizer latency: the octet must be held over to the next window rather than lost or sent early. Further tests pulse only the strobe that is not selected, switch between the two strobes, and hold a strobe high for longer than eight cycles, to check that the strobe choice and the idle level outside a burst are correct.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

    // How a window treats the octets that arrived since the last window
    typedef enum logic [1:0] {
        PLAY_FRESH  = 2'd0,
        PLAY_REPEAT = 2'd1,
        PLAY_DROP   = 2'd2
    } play_e;

    localparam int PEND_W = 2;

    function automatic play_e classify(input logic [PEND_W-1:0] fresh);
        if (fresh == '0)
            return PLAY_REPEAT;
        else if (fresh == PEND_W'(1))
            return PLAY_FRESH;
        else
            return PLAY_DROP;
    endfunction

endpackage

// File: rtl/tslot_wr_store.sv
module tslot_wr_store #(
    parameter int OCT_W = 8,
    parameter int SLOTS = 2
) (
    input  logic                        wr_clk,
    input  logic                        wr_rst_n,
    input  logic                        wr_en,
    input  logic [OCT_W-1:0]            wr_octet,
    output logic [SLOTS-1:0][OCT_W-1:0] slots_o,
    output logic                        tog_o
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [SLOTS-1:0][OCT_W-1:0] mem;
        logic [IDX_W-1:0]            ptr;
        logic                        tog;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.ptr] = wr_octet;
            st_d.ptr = (st_q.ptr == IDX_W'(SLOTS-1)) ? '0 : st_q.ptr + 1'b1;
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            st_q.mem <= '1;
            st_q.ptr <= '0;
            st_q.tog <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots_o = st_q.mem;
    assign tog_o   = st_q.tog;

endmodule

// File: rtl/tslot_sync.sv
module tslot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tslot_play.sv
module tslot_play
    import tslot_pkg::*;
#(
    parameter int OCT_W = 8,
    parameter int SLOTS = 2
) (
    input  logic                        rd_clk,
    input  logic                        rd_rst_n,
    input  logic                        strb,
    input  logic                        tog_s,
    input  logic [SLOTS-1:0][OCT_W-1:0] slots_i,
    output logic                        pcm_o,
    output logic                        rep_o,
    output logic                        del_o
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(OCT_W + 1);

    typedef struct packed {
        logic [OCT_W-1:0]  shreg;
        logic [OCT_W-1:0]  last;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [PEND_W-1:0] pend;
        logic              tog_prev;
        logic              strb_prev;
        logic              pcm;
        logic              rep;
        logic              del;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic              fresh_edge;
    logic              start;
    logic [IDX_W-1:0]  idx_now;
    logic [PEND_W-1:0] pend_now;
    play_e             kind;
    logic [OCT_W-1:0]  pick;

    always_comb begin
        st_d       = st_q;
        fresh_edge = tog_s ^ st_q.tog_prev;
        start      = strb & ~st_q.strb_prev;

        if (fresh_edge)
            idx_now = (st_q.idx == IDX_W'(SLOTS-1)) ? '0 : st_q.idx + 1'b1;
        else
            idx_now = st_q.idx;

        if (fresh_edge && st_q.pend != PEND_W'(2))
            pend_now = st_q.pend + 1'b1;
        else
            pend_now = st_q.pend;

        kind = classify(pend_now);
        pick = (kind == PLAY_REPEAT) ? st_q.last : slots_i[idx_now];

        st_d.tog_prev  = tog_s;
        st_d.strb_prev = strb;
        st_d.idx       = idx_now;
        st_d.pend      = pend_now;
        st_d.del       = 1'b0;

        if (start) begin
            st_d.last  = pick;
            st_d.pcm   = pick[OCT_W-1];
            st_d.shreg = {pick[OCT_W-2:0], 1'b1};
            st_d.cnt   = CNT_W'(OCT_W-1);
            st_d.rep   = (kind == PLAY_REPEAT);
            st_d.del   = (kind == PLAY_DROP);
            st_d.pend  = '0;
        end else if (strb && st_q.cnt != '0) begin
            st_d.pcm   = st_q.shreg[OCT_W-1];
            st_d.shreg = {st_q.shreg[OCT_W-2:0], 1'b1};
            st_d.cnt   = st_q.cnt - 1'b1;
        end else begin
            st_d.pcm   = 1'b1;
            st_d.rep   = 1'b0;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            st_q.shreg     <= '1;
            st_q.last      <= '1;
            st_q.cnt       <= '0;
            st_q.idx       <= IDX_W'(SLOTS-1);
            st_q.pend      <= '0;
            st_q.tog_prev  <= 1'b0;
            st_q.strb_prev <= 1'b0;
            st_q.pcm       <= 1'b1;
            st_q.rep       <= 1'b0;
            st_q.del       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcm_o = st_q.pcm;
    assign rep_o = st_q.rep;
    assign del_o = st_q.del;

endmodule

// File: rtl/tslot_slip_buf.sv
module tslot_slip_buf #(
    parameter int OCT_W       = 8,
    parameter int SLOTS       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [OCT_W-1:0] wr_octet,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             ts_a,
    input  logic             ts_b,
    input  logic             ts_pick,
    output logic             pcm_out,
    output logic             rep_flag,
    output logic             del_flag
);
    logic [SLOTS-1:0][OCT_W-1:0] slots;
    logic                        wr_tog;
    logic                        wr_tog_s;
    logic                        strb;

    assign strb = ts_pick ? ts_a : ts_b;

    tslot_wr_store #(.OCT_W(OCT_W), .SLOTS(SLOTS)) u_store (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_octet (wr_octet),
        .slots_o  (slots),
        .tog_o    (wr_tog)
    );

    tslot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_tog),
        .q     (wr_tog_s)
    );

    tslot_play #(.OCT_W(OCT_W), .SLOTS(SLOTS)) u_play (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .strb     (strb),
        .tog_s    (wr_tog_s),
        .slots_i  (slots),
        .pcm_o    (pcm_out),
        .rep_o    (rep_flag),
        .del_o    (del_flag)
    );

endmodule

// File: rtl/tslot_slip_buf_chk.sv
module tslot_slip_buf_chk (
    input logic rd_clk,
    input logic rd_rst_n,
    input logic ts_a,
    input logic ts_b,
    input logic ts_pick,
    input logic pcm_out,
    input logic rep_flag,
    input logic del_flag
);
    logic sel;
    assign sel = ts_pick ? ts_a : ts_b;

    AST_IDLE_WHEN_LOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !sel |=> pcm_out) else $error("idle level lost"); // R4

    AST_FLAGS_EXCL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(rep_flag && del_flag)) else $error("flags overlap"); // R8

    AST_DEL_ONE_CYCLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        del_flag |=> !del_flag) else $error("delete pulse too long"); // R8

    AST_DEL_AT_OPEN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        del_flag |-> ($past(sel) && !$past(sel, 2))) else $error("delete away from window open"); // R7

    AST_REP_AT_OPEN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rep_flag) |-> ($past(sel) && !$past(sel, 2))) else $error("repeat away from window open"); // R6

    AST_REP_IN_WINDOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rep_flag |-> $past(sel)) else $error("repeat outside window"); // R6

endmodule

bind tslot_slip_buf tslot_slip_buf_chk u_chk (.*);

// File: tb/tslot_slip_buf_tb.sv
`timescale 1ns/1ps
module tslot_slip_buf_tb;

    logic       wr_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_octet = 8'h00;
    logic       rd_clk = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       ts_a = 1'b0;
    logic       ts_b = 1'b0;
    logic       ts_pick = 1'b1;
    logic       pcm_out;
    logic       rep_flag;
    logic       del_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 rd_clk = ~rd_clk;

    tslot_slip_buf u_dut (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_octet (wr_octet),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .ts_a     (ts_a),
        .ts_b     (ts_b),
        .ts_pick  (ts_pick),
        .pcm_out  (pcm_out),
        .rep_flag (rep_flag),
        .del_flag (del_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_octet(input logic [7:0] v, input int gap);
        @(negedge rd_clk);
        wr_octet = v;
        wr_en    = 1'b1;
        #0.5 wr_clk = 1'b1;
        #1.0 wr_clk = 1'b0;
        wr_en = 1'b0;
        repeat (gap) @(negedge rd_clk);
    endtask

    // Opens one window on the chosen strobe for len cycles and checks every cycle
    task automatic run_window(input bit use_a, input int len, input logic [7:0] exp,
                              input bit exp_rep, input bit exp_del, input string req);
        @(negedge rd_clk);
        ts_pick = use_a;
        if (use_a) ts_a = 1'b1; else ts_b = 1'b1;
        for (int k = 1; k <= len; k++) begin
            @(negedge rd_clk);
            if (k <= 8) begin
                check(pcm_out == exp[8-k], req, "burst bit", {7'd0, pcm_out}, {7'd0, exp[8-k]});
                check(rep_flag == exp_rep, req, "rep_flag in burst", {7'd0, rep_flag}, {7'd0, exp_rep});
                check(del_flag == (exp_del && k == 1), req, "del_flag in burst",
                      {7'd0, del_flag}, {7'd0, exp_del && k == 1});
            end else begin
                check(pcm_out == 1'b1, "R4", "after burst", {7'd0, pcm_out}, 8'd1);
                check(!rep_flag && !del_flag, "R4", "flags after burst",
                      {6'd0, rep_flag, del_flag}, 8'd0);
            end
        end
        ts_a = 1'b0;
        ts_b = 1'b0;
        @(negedge rd_clk);
        check(pcm_out == 1'b1, "R4", "idle after window", {7'd0, pcm_out}, 8'd1);
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic t_reset();
        check(pcm_out == 1'b1, "R1", "pcm_out at reset", {7'd0, pcm_out}, 8'd1);
        check(!rep_flag, "R1", "rep_flag at reset", {7'd0, rep_flag}, 8'd0);
        check(!del_flag, "R1", "del_flag at reset", {7'd0, del_flag}, 8'd0);
    endtask

    task automatic t_empty();      // R9
        run_window(1'b1, 8, 8'hFF, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_fresh();      // R3 R5
        write_octet(8'hA5, 6);
        run_window(1'b1, 8, 8'hA5, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_unselected(); // R2
        @(negedge rd_clk);
        ts_pick = 1'b1;
        ts_b    = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(negedge rd_clk);
            check(pcm_out == 1'b1, "R2", "unselected strobe output", {7'd0, pcm_out}, 8'd1);
            check(!rep_flag && !del_flag, "R2", "unselected strobe flags",
                  {6'd0, rep_flag, del_flag}, 8'd0);
        end
        ts_b = 1'b0;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic t_repeat();     // R6
        run_window(1'b1, 8, 8'hA5, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_drop();       // R7 R8
        write_octet(8'h3C, 6);
        write_octet(8'hC3, 6);
        run_window(1'b1, 8, 8'hC3, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_pick_b();     // R2 R3
        write_octet(8'h81, 6);
        run_window(1'b0, 8, 8'h81, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_long();       // R4
        write_octet(8'h7E, 6);
        run_window(1'b0, 12, 8'h7E, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_late();       // R10
        write_octet(8'h5A, 0);
        run_window(1'b0, 8, 8'h7E, 1'b1, 1'b0, "R10");
        run_window(1'b0, 8, 8'h5A, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_triple();     // R7 with slot wrap
        write_octet(8'h11, 6);
        write_octet(8'h22, 6);
        write_octet(8'h33, 6);
        run_window(1'b1, 8, 8'h33, 1'b0, 1'b1, "R7");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        t_reset();
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        t_reset();
        t_empty();
        t_fresh();
        t_unselected();
        t_repeat();
        t_drop();
        t_pick_b();
        t_long();
        t_late();
        t_triple();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule